// File: doc/BRIEF.md
# Dynamic Ring Shortcut Router

This block sits at a junction that splits a unidirectional ring into two segments, called side A and side B. Each side has one input (flits leaving that segment towards the junction) and one output (flits entering that segment from the junction). Without the junction, the ring simply carries a flit from the A input to the B output and from the B input to the A output. The junction can also turn a flit back into the segment it came from. It makes this choice every cycle from the destination address each flit carries. No configuration register is involved.

Each flit goes to the output on its destination's side. When both flits want the same output, the flit that is crossing the junction gets it. The other flit is sent onward along the full ring and is never dropped. It loops around and comes back to the junction later, so every destination on the ring stays reachable and nothing livelocks. Every flit spends exactly two clock cycles in the block. Traffic that always targets the far segment therefore just follows the plain ring path and pays only that latency.

Top module: `ring_shortcut_router`

## Requirements
- R1: While rst_n is low and in the cycle after reset, both outputs are invalid.
- R2: A valid flit on the A input whose destination lies in segment B leaves on the B output. A valid flit on the B input whose destination lies in segment A leaves on the A output. This is the plain ring path.
- R3: A valid flit whose destination lies in its own arrival segment is reflected. From the A input it leaves on the A output; from the B input it leaves on the B output.
- R4: A destination belongs to segment A exactly when A_FIRST <= dest <= A_LAST. Every other address belongs to segment B. With the defaults (8 nodes, A_FIRST=0, A_LAST=3), addresses 0..3 are in A and 4..7 are in B.
- R5: When both inputs are valid and both destinations lie in the same segment, the crossing flit takes that segment's output. The other flit takes the remaining output, which is the ring-continuing direction, with its address and data intact.
- R6: Every valid input flit appears exactly once on exactly one output, with dest and data unchanged. Flits are never dropped or duplicated.
- R7: A flit presented in a cycle appears on its output exactly two clock cycles later, never earlier or later, whatever the traffic.
- R8: Invalid input slots never claim an output. A lone valid flit always gets the output on its destination's side, and with no valid input both outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in_valid | input | 1 | Flit present on the A-side input |
| a_in_dest | input | AW | Destination node of the A-side input flit |
| a_in_data | input | DATA_W | Payload of the A-side input flit |
| b_in_valid | input | 1 | Flit present on the B-side input |
| b_in_dest | input | AW | Destination node of the B-side input flit |
| b_in_data | input | DATA_W | Payload of the B-side input flit |
| a_out_valid | output | 1 | Flit present on the output into segment A |
| a_out_dest | output | AW | Destination of the A-side output flit |
| a_out_data | output | DATA_W | Payload of the A-side output flit |
| b_out_valid | output | 1 | Flit present on the output into segment B |
| b_out_dest | output | AW | Destination of the B-side output flit |
| b_out_data | output | DATA_W | Payload of the B-side output flit |

## Verification
The bench targets the two contention cases, where both flits head for segment A or both head for segment B. A design that favoured the reflecting flit would starve the crossing one, and a design that dropped the loser would lose flits. It also probes the addresses on either side of the A_LAST/A_FIRST boundary, where an off-by-one in the segment compare would reflect a flit that should cross. A single flit is watched cycle by cycle to catch a pipeline that is one stage short or long. Invalid slots carry stale addresses, which catches logic that lets an empty slot steal an output.

// File: rtl/ring_junction_pkg.sv
// Shared types for the ring shortcut router.
// Assumes a two-sided junction: side A and side B.
package ring_junction_pkg;
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    typedef enum logic {
        MAP_THROUGH = 1'b0,  // A input -> B output, B input -> A output
        MAP_REFLECT = 1'b1   // A input -> A output, B input -> B output
    } map_e;
endpackage

// File: rtl/seg_classify.sv
// Decides which ring segment a destination address lies in.
// Assumes segment A is the contiguous range A_FIRST..A_LAST and
// segment B is every other node on the ring.
module seg_classify
    import ring_junction_pkg::*;
#(
    parameter int N_NODES = 8,
    parameter int A_FIRST = 0,
    parameter int A_LAST  = 3,
    localparam int AW     = $clog2(N_NODES)
) (
    input  logic [AW-1:0] dest,
    output side_e         dest_side
);
    int d_int;

    // Range compare of the destination against the segment A bounds.
    always_comb begin
        d_int     = int'(dest);
        dest_side = ((d_int >= A_FIRST) && (d_int <= A_LAST)) ? SIDE_A : SIDE_B;
    end
endmodule

// File: rtl/flit_reg.sv
// One pipeline register for a flit: a valid bit plus a packed body.
// Assumes a synchronous active-low reset that clears valid and body.
module flit_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_bits,
    output logic         out_valid,
    output logic [W-1:0] out_bits
);
    // Capture the incoming flit every cycle; reset empties the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= in_valid;
            out_bits  <= in_bits;
        end
    end
endmodule

// File: rtl/junction_steer.sv
// Steering decision for the junction. Each flit asks for the output on
// its destination's side. Empty slots ask for nothing. On a clash the
// crossing flit wins and the other flit continues along the ring.
// Assumes the junction only swaps or keeps the two flits, so the two
// outcomes form a single map choice.
module junction_steer
    import ring_junction_pkg::*;
(
    input  logic  vld_a,
    input  side_e want_a,
    input  logic  vld_b,
    input  side_e want_b,
    output map_e  route
);
    logic clash;
    logic a_gets_own;
    logic b_gets_own;

    // Detect two valid flits asking for the same output.
    always_comb begin
        clash = vld_a && vld_b && (want_a == want_b);
    end

    // Grant: a flit keeps its own side only if it asked for it and no crossing flit claims it.
    always_comb begin
        a_gets_own = vld_a && (want_a == SIDE_A) && !(vld_b && (want_b == SIDE_A));
        b_gets_own = vld_b && (want_b == SIDE_B) && !(vld_a && (want_a == SIDE_B));
    end

    // Reflect when some valid flit is granted its own side; otherwise follow the ring.
    always_comb begin
        if (clash) begin
            route = MAP_THROUGH;
        end else if (a_gets_own || b_gets_own) begin
            route = MAP_REFLECT;
        end else begin
            route = MAP_THROUGH;
        end
    end
endmodule

// File: rtl/ring_shortcut_router.sv
// Ring segment junction with per-cycle shortcut steering.
// Stage 1 registers both input flits together with their destination
// side. Stage 2 registers the steered flits onto the outputs.
// Every flit therefore spends two cycles in the block.
// Assumes single-flit packets and an output slot that is always free
// on the next hop, as on a bufferless deflection ring.
module ring_shortcut_router
    import ring_junction_pkg::*;
#(
    parameter int N_NODES = 8,
    parameter int A_FIRST = 0,
    parameter int A_LAST  = 3,
    parameter int DATA_W  = 16,
    localparam int AW     = $clog2(N_NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_in_valid,
    input  logic [AW-1:0]     a_in_dest,
    input  logic [DATA_W-1:0] a_in_data,
    input  logic              b_in_valid,
    input  logic [AW-1:0]     b_in_dest,
    input  logic [DATA_W-1:0] b_in_data,
    output logic              a_out_valid,
    output logic [AW-1:0]     a_out_dest,
    output logic [DATA_W-1:0] a_out_data,
    output logic              b_out_valid,
    output logic [AW-1:0]     b_out_dest,
    output logic [DATA_W-1:0] b_out_data
);
    localparam int BODY_W = AW + DATA_W;
    localparam int S1_W   = BODY_W + 1;
    localparam int NSIDE  = 2;

    logic              in_valid [NSIDE];
    logic [AW-1:0]     in_dest  [NSIDE];
    logic [DATA_W-1:0] in_data  [NSIDE];
    side_e             in_side  [NSIDE];
    logic              s1_valid [NSIDE];
    logic [S1_W-1:0]   s1_bits  [NSIDE];
    side_e             s1_want  [NSIDE];
    logic              s2_in_valid [NSIDE];
    logic [BODY_W-1:0] s2_in_bits  [NSIDE];
    logic              s2_valid [NSIDE];
    logic [BODY_W-1:0] s2_bits  [NSIDE];
    map_e              route;

    // Gather the side ports into arrays indexed by side.
    always_comb begin
        in_valid[0] = a_in_valid;
        in_dest[0]  = a_in_dest;
        in_data[0]  = a_in_data;
        in_valid[1] = b_in_valid;
        in_dest[1]  = b_in_dest;
        in_data[1]  = b_in_data;
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        seg_classify #(
            .N_NODES (N_NODES),
            .A_FIRST (A_FIRST),
            .A_LAST  (A_LAST)
        ) u_cls (
            .dest      (in_dest[g]),
            .dest_side (in_side[g])
        );

        flit_reg #(.W(S1_W)) u_s1 (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[g]),
            .in_bits   ({in_side[g], in_dest[g], in_data[g]}),
            .out_valid (s1_valid[g]),
            .out_bits  (s1_bits[g])
        );

        // Recover the registered destination side from stage 1.
        always_comb begin
            s1_want[g] = side_e'(s1_bits[g][S1_W-1]);
        end

        flit_reg #(.W(BODY_W)) u_s2 (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (s2_in_valid[g]),
            .in_bits   (s2_in_bits[g]),
            .out_valid (s2_valid[g]),
            .out_bits  (s2_bits[g])
        );
    end

    junction_steer u_steer (
        .vld_a  (s1_valid[0]),
        .want_a (s1_want[0]),
        .vld_b  (s1_valid[1]),
        .want_b (s1_want[1]),
        .route  (route)
    );

    // Output crossbar: keep sides on reflect, swap them on the ring path.
    always_comb begin
        if (route == MAP_REFLECT) begin
            s2_in_valid[0] = s1_valid[0];
            s2_in_bits[0]  = s1_bits[0][BODY_W-1:0];
            s2_in_valid[1] = s1_valid[1];
            s2_in_bits[1]  = s1_bits[1][BODY_W-1:0];
        end else begin
            s2_in_valid[0] = s1_valid[1];
            s2_in_bits[0]  = s1_bits[1][BODY_W-1:0];
            s2_in_valid[1] = s1_valid[0];
            s2_in_bits[1]  = s1_bits[0][BODY_W-1:0];
        end
    end

    // Drive the side ports from the stage 2 registers.
    always_comb begin
        a_out_valid = s2_valid[0];
        a_out_dest  = s2_bits[0][BODY_W-1:DATA_W];
        a_out_data  = s2_bits[0][DATA_W-1:0];
        b_out_valid = s2_valid[1];
        b_out_dest  = s2_bits[1][BODY_W-1:DATA_W];
        b_out_data  = s2_bits[1][DATA_W-1:0];
    end
endmodule

// File: rtl/ring_junction_chk.sv
// Assertion checker for ring_shortcut_router, attached with bind.
// Assumes the default two-cycle pipeline. A small counter blocks any
// look-back that would reach across reset.
module ring_junction_chk #(
    parameter int N_NODES = 8,
    parameter int A_FIRST = 0,
    parameter int A_LAST  = 3,
    parameter int DATA_W  = 16,
    localparam int AW     = $clog2(N_NODES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_in_valid,
    input logic [AW-1:0]     a_in_dest,
    input logic [DATA_W-1:0] a_in_data,
    input logic              b_in_valid,
    input logic [AW-1:0]     b_in_dest,
    input logic [DATA_W-1:0] b_in_data,
    input logic              a_out_valid,
    input logic [AW-1:0]     a_out_dest,
    input logic [DATA_W-1:0] a_out_data,
    input logic              b_out_valid,
    input logic [AW-1:0]     b_out_dest,
    input logic [DATA_W-1:0] b_out_data
);
    logic [1:0] since_rst;
    logic       warm;
    logic       a_to_a;
    logic       b_to_a;

    // Count cycles since reset, saturating, to gate two-cycle look-back.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Segment A membership of each input destination (R4 rule).
    always_comb begin
        warm   = (since_rst >= 2'd2);
        a_to_a = (int'(a_in_dest) >= A_FIRST) && (int'(a_in_dest) <= A_LAST);
        b_to_a = (int'(b_in_dest) >= A_FIRST) && (int'(b_in_dest) <= A_LAST);
    end

    // R1: outputs are empty the cycle after reset is held.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!a_out_valid && !b_out_valid));

    // R6: valid flit count is conserved through the two stages.
    a_r6_count_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> ($countones({a_out_valid, b_out_valid}) ==
                  $countones($past({a_in_valid, b_in_valid}, 2))));

    // R5: both flits bound for segment B, the crossing A flit wins output B.
    a_r5_cross_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(a_in_valid && b_in_valid && !a_to_a && !b_to_a, 2)) |->
        (b_out_valid && b_out_data == $past(a_in_data, 2) &&
         a_out_valid && a_out_data == $past(b_in_data, 2)));

    // R5: both flits bound for segment A, the crossing B flit wins output A.
    a_r5_cross_wins_a: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(a_in_valid && b_in_valid && a_to_a && b_to_a, 2)) |->
        (a_out_valid && a_out_data == $past(b_in_data, 2) &&
         b_out_valid && b_out_data == $past(a_in_data, 2)));

    // R3/R8: a lone A flit for its own segment is reflected to output A.
    a_r3_lone_reflect: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(a_in_valid && !b_in_valid && a_to_a, 2)) |->
        (a_out_valid && !b_out_valid && a_out_dest == $past(a_in_dest, 2)));

    // R8: no valid input means no valid output.
    a_r8_idle_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(!a_in_valid && !b_in_valid, 2)) |->
        (!a_out_valid && !b_out_valid));
endmodule

bind ring_shortcut_router ring_junction_chk #(
    .N_NODES (N_NODES),
    .A_FIRST (A_FIRST),
    .A_LAST  (A_LAST),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_in_valid  (a_in_valid),
    .a_in_dest   (a_in_dest),
    .a_in_data   (a_in_data),
    .b_in_valid  (b_in_valid),
    .b_in_dest   (b_in_dest),
    .b_in_data   (b_in_data),
    .a_out_valid (a_out_valid),
    .a_out_dest  (a_out_dest),
    .a_out_data  (a_out_data),
    .b_out_valid (b_out_valid),
    .b_out_dest  (b_out_dest),
    .b_out_data  (b_out_data)
);

// File: tb/ring_shortcut_router_tb.sv
// Self-checking bench for ring_shortcut_router. A behavioural model
// predicts each output pair and the prediction is compared every clock.
module ring_shortcut_router_tb;
    localparam int N_NODES = 8;
    localparam int A_FIRST = 0;
    localparam int A_LAST  = 3;
    localparam int DATA_W  = 16;
    localparam int AW      = 3;

    typedef struct {
        logic              av;
        logic [AW-1:0]     ad;
        logic [DATA_W-1:0] adat;
        logic              bv;
        logic [AW-1:0]     bd;
        logic [DATA_W-1:0] bdat;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              a_in_valid = 1'b0;
    logic [AW-1:0]     a_in_dest = '0;
    logic [DATA_W-1:0] a_in_data = '0;
    logic              b_in_valid = 1'b0;
    logic [AW-1:0]     b_in_dest = '0;
    logic [DATA_W-1:0] b_in_data = '0;
    logic              a_out_valid;
    logic [AW-1:0]     a_out_dest;
    logic [DATA_W-1:0] a_out_data;
    logic              b_out_valid;
    logic [AW-1:0]     b_out_dest;
    logic [DATA_W-1:0] b_out_data;

    int   checks = 0;
    int   errors = 0;
    int   sent = 0;
    int   seen = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    ring_shortcut_router #(
        .N_NODES (N_NODES),
        .A_FIRST (A_FIRST),
        .A_LAST  (A_LAST),
        .DATA_W  (DATA_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .a_in_valid (a_in_valid), .a_in_dest (a_in_dest), .a_in_data (a_in_data),
        .b_in_valid (b_in_valid), .b_in_dest (b_in_dest), .b_in_data (b_in_data),
        .a_out_valid (a_out_valid), .a_out_dest (a_out_dest), .a_out_data (a_out_data),
        .b_out_valid (b_out_valid), .b_out_dest (b_out_dest), .b_out_data (b_out_data)
    );

    function automatic bit in_seg_a(input logic [AW-1:0] d);
        return (int'(d) >= A_FIRST) && (int'(d) <= A_LAST);
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Model: each flit wants its destination side; on a clash the crossing flit wins.
    function automatic exp_t predict(input logic va, input logic [AW-1:0] da, input logic [DATA_W-1:0] xa,
                                     input logic vb, input logic [AW-1:0] db, input logic [DATA_W-1:0] xb,
                                     input string tag);
        exp_t e;
        bit a_own;
        bit b_own;
        e.av = 1'b0; e.ad = '0; e.adat = '0;
        e.bv = 1'b0; e.bd = '0; e.bdat = '0;
        e.tag = tag;
        a_own = va && in_seg_a(da);
        b_own = vb && !in_seg_a(db);
        if (va && vb && (in_seg_a(da) == in_seg_a(db))) begin
            a_own = 1'b0;
            b_own = 1'b0;
        end
        if (va) begin
            if (a_own) begin e.av = 1'b1; e.ad = da; e.adat = xa; end
            else       begin e.bv = 1'b1; e.bd = da; e.bdat = xa; end
        end
        if (vb) begin
            if (b_own) begin e.bv = 1'b1; e.bd = db; e.bdat = xb; end
            else       begin e.av = 1'b1; e.ad = db; e.adat = xb; end
        end
        return e;
    endfunction

    // One cycle: compare outputs with the prediction from two cycles back, then drive.
    task automatic step(input logic va, input logic [AW-1:0] da, input logic [DATA_W-1:0] xa,
                        input logic vb, input logic [AW-1:0] db, input logic [DATA_W-1:0] xb,
                        input string tag);
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        check(e.tag, "a_out_valid", 32'(a_out_valid), 32'(e.av));
        check(e.tag, "b_out_valid", 32'(b_out_valid), 32'(e.bv));
        if (e.av) check(e.tag, "a_out dest/data", {13'd0, a_out_dest, a_out_data}, {13'd0, e.ad, e.adat});
        if (e.bv) check(e.tag, "b_out dest/data", {13'd0, b_out_dest, b_out_data}, {13'd0, e.bd, e.bdat});
        seen += int'(a_out_valid) + int'(b_out_valid);
        sent += int'(va) + int'(vb);
        exp_q.push_back(predict(va, da, xa, vb, db, xb, tag));
        a_in_valid = va; a_in_dest = da; a_in_data = xa;
        b_in_valid = vb; b_in_dest = db; b_in_data = xb;
    endtask

    initial begin
        exp_t idle;
        idle = predict(1'b0, '0, '0, 1'b0, '0, '0, "R1");
        repeat (3) @(negedge clk);
        // R1: outputs empty while reset is held.
        check("R1", "a_out_valid in reset", 32'(a_out_valid), 32'd0);
        check("R1", "b_out_valid in reset", 32'(b_out_valid), 32'd0);
        rst_n = 1'b1;
        exp_q.push_back(idle);
        exp_q.push_back(idle);

        // R2: crossing in both directions, plain ring path.
        step(1, 3'd6, 16'hA001, 0, 3'd2, 16'h0000, "R2");
        step(0, 3'd1, 16'h0000, 1, 3'd1, 16'hB002, "R2");
        step(1, 3'd5, 16'hA003, 1, 3'd0, 16'hB003, "R2");
        // R3: reflection in both directions.
        step(1, 3'd2, 16'hA011, 0, 3'd0, 16'h0000, "R3");
        step(0, 3'd0, 16'h0000, 1, 3'd7, 16'hB012, "R3");
        step(1, 3'd1, 16'hA013, 1, 3'd4, 16'hB013, "R3");
        // R4: addresses on the segment boundaries.
        step(1, 3'(A_LAST), 16'hA021, 0, 3'd0, 16'h0000, "R4");
        step(1, 3'(A_LAST + 1), 16'hA022, 0, 3'd0, 16'h0000, "R4");
        step(0, 3'd0, 16'h0000, 1, 3'(A_FIRST), 16'hB023, "R4");
        step(0, 3'd0, 16'h0000, 1, 3'(N_NODES - 1), 16'hB024, "R4");
        // R5: contention, crossing flit wins the shared output.
        step(1, 3'd5, 16'hA031, 1, 3'd6, 16'hB031, "R5");
        step(1, 3'd0, 16'hA032, 1, 3'd3, 16'hB032, "R5");
        step(1, 3'(A_LAST), 16'hA033, 1, 3'(A_FIRST), 16'hB033, "R5");
        // R8: empty slots with stale addresses claim nothing.
        step(0, 3'd7, 16'hDEAD, 0, 3'd0, 16'hBEEF, "R8");
        step(0, 3'd1, 16'hDEAD, 1, 3'd6, 16'hB041, "R8");
        step(1, 3'd6, 16'hA042, 0, 3'd2, 16'hBEEF, "R8");
        // R7: a single flit after idle; an early or late arrival mismatches.
        step(0, 3'd0, 16'h0000, 0, 3'd0, 16'h0000, "R7");
        step(1, 3'd2, 16'hA051, 0, 3'd0, 16'h0000, "R7");
        step(0, 3'd0, 16'h0000, 0, 3'd0, 16'h0000, "R7");
        step(0, 3'd0, 16'h0000, 0, 3'd0, 16'h0000, "R7");
        // R6: random traffic, per-cycle comparison.
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, N_NODES - 1)), 16'($urandom),
                 1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, N_NODES - 1)), 16'($urandom), "R6");
        end
        step(0, 3'd0, 16'h0000, 0, 3'd0, 16'h0000, "R6");
        step(0, 3'd0, 16'h0000, 0, 3'd0, 16'h0000, "R6");
        @(negedge clk);
        seen += int'(a_out_valid) + int'(b_out_valid);
        // R6: every flit sent came out exactly once.
        check("R6", "flits out vs in", 32'(seen), 32'(sent));
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule